// File: doc/BRIEF.md
# Low-Power Stop Wake Controller

This block puts a small microcontroller into a low-power stop state and brings it back out. When the processor raises a stop request, the block records the interrupt priority mask that travels with that request. It then turns off the processor clock. Two keep bits decide whether the internal timer clock and the external bus clock go on running. Any clock that is switched off is held low. The block leaves stop on reset, on a trace request, or on an interrupt whose level is above the recorded mask.

When both keep bits are clear, the phase-locked loop is powered down for the stop period. On wake the block then spends a relock interval with every clock still held low, and only after that releases them. The interval is a programmable count of reference cycles, and a lock indication from the loop can cut it short. Each module has a stop bit that gates that module's clock. The stop bits stay readable and writable at all times. During stop the pads hold their last output values, pads set as inputs stay undriven, and the bus strobes are forced inactive.

Top module: `lpstop_wake_ctrl`

## Requirements
- R1: In RUN (mode_o = 0), stop_req moves the block to STOP (mode_o = 1) at the next clock edge and loads stop_mask into held_mask. A stop_req seen in STOP or RELOCK (mode_o = 2) has no effect on the mode or on held_mask.
- R2: held_mask does not change while the block stays in STOP.
- R3: In STOP, an irq_level strictly greater than held_mask ends STOP at the next edge, and level 7 ends it even when held_mask is 7. A level at or below held_mask, including level 0, leaves the block in STOP.
- R4: trace_req in STOP ends STOP at the next edge, whatever the mask and the interrupt level.
- R5: rst_n low forces RUN at once, sets held_mask to 0 and clears all module stop bits.
- R6: cpu_clk toggles with clk_ref in RUN. It is held low in STOP and in RELOCK.
- R7: In STOP, int_clk runs only when keep_int is 1 and the clock source is not lost. The source counts as lost when ext_clk_mode is 1 and ext_src_ok is 0. Otherwise int_clk is held low. It runs in RUN and is held low in RELOCK.
- R8: In STOP, ext_clk runs only when keep_ext is 1, and is held low otherwise. It runs in RUN and is held low in RELOCK.
- R9: pll_en is 0 in STOP exactly when keep_int and keep_ext are both 0. A wake in that case enters RELOCK. The block stays in RELOCK for relock_len cycles, or for 16 cycles when relock_len is 0, and then returns to RUN. A wake in any other case goes straight to RUN.
- R10: lock_ok high in RELOCK returns the block to RUN at the next edge.
- R11: mod_stop_we writes mod_stop_wd into mod_stop_q in any mode. mod_clk[i] runs only in RUN and only while mod_stop_q[i] is 0.
- R12: In RUN, pad_oe follows pad_dir (1 = output) and pad_o follows pad_out_i. In STOP and RELOCK, both keep the values sampled at the edge that entered STOP. In STOP and RELOCK, bus_strb_o is 0. In RUN it follows bus_strb_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | System reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| stop_req | input | 1 | Stop request from the processor |
| stop_mask | input | 3 | Interrupt mask sent with the stop request |
| irq_level | input | 3 | Highest pending interrupt level, 0 = none |
| trace_req | input | 1 | Trace exception request |
| keep_int | input | 1 | Keep the internal clock running in stop |
| keep_ext | input | 1 | Keep the external clock running in stop |
| ext_clk_mode | input | 1 | Clock is taken from an external source |
| ext_src_ok | input | 1 | External clock source is present |
| relock_len | input | 8 | Relock wait in cycles, 0 selects 16 |
| lock_ok | input | 1 | Loop reports lock |
| mod_stop_we | input | 1 | Write strobe for the module stop bits |
| mod_stop_wd | input | 8 | Write data for the module stop bits |
| pad_dir | input | 8 | Pad direction, 1 = output |
| pad_out_i | input | 8 | Pad output values from the system |
| bus_strb_i | input | 4 | Bus strobes from the system |
| mode_o | output | 2 | 0 RUN, 1 STOP, 2 RELOCK |
| held_mask | output | 3 | Mask recorded at stop entry |
| mod_stop_q | output | 8 | Module stop bits |
| cpu_clk | output | 1 | Gated processor clock |
| int_clk | output | 1 | Gated internal timer clock |
| ext_clk | output | 1 | Gated external bus clock |
| mod_clk | output | 8 | Gated per-module clocks |
| pll_en | output | 1 | Loop power enable |
| pad_oe | output | 8 | Pad output enables |
| pad_o | output | 8 | Pad output values |
| bus_strb_o | output | 4 | Bus strobes after stop gating |

## Verification
The bench aims at the edges of the mask comparison:
- A level equal to the mask must not wake the block. A design using greater-or-equal would leave stop too early.
- Level 7 against mask 7 must wake the block. A design that compares strictly without the level-7 exception would never wake on it.
- A stop request repeated while stopped must leave the mask alone. A design that reloads the mask would change which interrupts can wake it.

The bench also measures how many cycles the block stays in RELOCK, including the case where relock_len is 0 and 16 cycles apply. An off-by-one counter would show there as 15 or 17 cycles.

For each combination of keep bits and lost source, the bench probes the gated clocks in their high phase. A gate left on, or one that holds its last level, would read high where the clock should be low.

// File: rtl/lpstop_wake_ctrl.sv
module lpstop_wake_ctrl #(
  parameter int N_MOD      = 8,
  parameter int N_PAD      = 8,
  parameter int N_STRB     = 4,
  parameter int LVL_W      = 3,
  parameter int CNT_W      = 8,
  parameter int RELOCK_DEF = 16
) (
  input  logic              clk_ref,
  input  logic              rst_n,
  input  logic              stop_req,
  input  logic [LVL_W-1:0]  stop_mask,
  input  logic [LVL_W-1:0]  irq_level,
  input  logic              trace_req,
  input  logic              keep_int,
  input  logic              keep_ext,
  input  logic              ext_clk_mode,
  input  logic              ext_src_ok,
  input  logic [CNT_W-1:0]  relock_len,
  input  logic              lock_ok,
  input  logic              mod_stop_we,
  input  logic [N_MOD-1:0]  mod_stop_wd,
  input  logic [N_PAD-1:0]  pad_dir,
  input  logic [N_PAD-1:0]  pad_out_i,
  input  logic [N_STRB-1:0] bus_strb_i,
  output logic [1:0]        mode_o,
  output logic [LVL_W-1:0]  held_mask,
  output logic [N_MOD-1:0]  mod_stop_q,
  output logic              cpu_clk,
  output logic              int_clk,
  output logic              ext_clk,
  output logic [N_MOD-1:0]  mod_clk,
  output logic              pll_en,
  output logic [N_PAD-1:0]  pad_oe,
  output logic [N_PAD-1:0]  pad_o,
  output logic [N_STRB-1:0] bus_strb_o
);

  localparam logic [LVL_W-1:0] TOP_LVL  = {LVL_W{1'b1}};
  localparam logic [CNT_W-1:0] DEF_LEN  = CNT_W'(RELOCK_DEF);
  localparam logic [CNT_W-1:0] ONE      = CNT_W'(1);

  typedef enum logic [1:0] {S_RUN = 2'd0, S_STOP = 2'd1, S_RELOCK = 2'd2} mode_t;

  mode_t            state;
  logic [CNT_W-1:0] cnt_q;
  logic [N_PAD-1:0] hold_dir, hold_val;
  logic             en_cpu, en_int, en_ext;
  logic [N_MOD-1:0] en_mod;

  wire running  = (state == S_RUN);
  wire stopped  = (state == S_STOP);
  wire pll_down = !keep_int && !keep_ext;
  wire src_lost = ext_clk_mode && !ext_src_ok;
  wire wake     = trace_req || (irq_level > held_mask) || (irq_level == TOP_LVL);
  wire [CNT_W-1:0] eff_len = (relock_len == '0) ? DEF_LEN : relock_len;

  always_ff @(posedge clk_ref or negedge rst_n) begin
    if (!rst_n) begin
      state     <= S_RUN;
      held_mask <= '0;
      cnt_q     <= '0;
      hold_dir  <= '0;
      hold_val  <= '0;
    end else begin
      unique case (state)
        S_RUN: if (stop_req) begin
          state     <= S_STOP;
          held_mask <= stop_mask;
          hold_dir  <= pad_dir;
          hold_val  <= pad_out_i;
        end
        S_STOP: if (wake) begin
          if (pll_down) begin
            state <= S_RELOCK;
            cnt_q <= eff_len;
          end else begin
            state <= S_RUN;
          end
        end
        S_RELOCK: begin
          if (lock_ok || cnt_q == ONE) state <= S_RUN;
          else                         cnt_q <= cnt_q - ONE;
        end
        default: state <= S_RUN;
      endcase
    end
  end

  always_ff @(posedge clk_ref or negedge rst_n) begin
    if (!rst_n)           mod_stop_q <= '0;
    else if (mod_stop_we) mod_stop_q <= mod_stop_wd;
  end

  always_ff @(negedge clk_ref or negedge rst_n) begin
    if (!rst_n) begin
      en_cpu <= 1'b0;
      en_int <= 1'b0;
      en_ext <= 1'b0;
      en_mod <= '0;
    end else begin
      en_cpu <= running;
      en_int <= running || (stopped && keep_int && !src_lost);
      en_ext <= running || (stopped && keep_ext);
      en_mod <= running ? ~mod_stop_q : '0;
    end
  end

  assign cpu_clk = clk_ref & en_cpu;
  assign int_clk = clk_ref & en_int;
  assign ext_clk = clk_ref & en_ext;

  for (genvar i = 0; i < N_MOD; i++) begin : g_mod
    assign mod_clk[i] = clk_ref & en_mod[i];
  end

  assign mode_o     = state;
  assign pll_en     = !(stopped && pll_down);
  assign pad_oe     = running ? pad_dir   : hold_dir;
  assign pad_o      = running ? pad_out_i : hold_val;
  assign bus_strb_o = running ? bus_strb_i : '0;

endmodule

// File: rtl/lpstop_wake_ctrl_chk.sv
module lpstop_wake_ctrl_chk #(
  parameter int LVL_W  = 3,
  parameter int N_STRB = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic [1:0]        mode_o,
  input logic              stop_req,
  input logic [LVL_W-1:0]  irq_level,
  input logic              trace_req,
  input logic [LVL_W-1:0]  held_mask,
  input logic              keep_int,
  input logic              keep_ext,
  input logic              lock_ok,
  input logic              pll_en,
  input logic [N_STRB-1:0] bus_strb_o
);
  localparam logic [LVL_W-1:0] TOP_LVL = {LVL_W{1'b1}};

  AST_ENTER_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == 2'd0 && stop_req) |=> (mode_o == 2'd1)); // R1
  AST_MASK_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == 2'd1 && $past(mode_o) == 2'd1) |-> $stable(held_mask)); // R2
  AST_LOW_LEVEL_SLEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == 2'd1 && !trace_req && irq_level <= held_mask && irq_level != TOP_LVL) |=> (mode_o == 2'd1)); // R3
  AST_HIGH_LEVEL_WAKES: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == 2'd1 && (irq_level > held_mask || irq_level == TOP_LVL)) |=> (mode_o != 2'd1)); // R3
  AST_TRACE_WAKES: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == 2'd1 && trace_req) |=> (mode_o != 2'd1)); // R4
  AST_PLL_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == 2'd1 && !keep_int && !keep_ext) |-> !pll_en); // R9
  AST_LOCK_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == 2'd2 && lock_ok) |=> (mode_o == 2'd0)); // R10
  AST_STROBES_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o != 2'd0) |-> (bus_strb_o == '0)); // R12
endmodule

bind lpstop_wake_ctrl lpstop_wake_ctrl_chk #(.LVL_W(LVL_W), .N_STRB(N_STRB)) u_chk (
  .clk(clk_ref), .rst_n(rst_n), .mode_o(mode_o), .stop_req(stop_req),
  .irq_level(irq_level), .trace_req(trace_req), .held_mask(held_mask),
  .keep_int(keep_int), .keep_ext(keep_ext), .lock_ok(lock_ok),
  .pll_en(pll_en), .bus_strb_o(bus_strb_o)
);

// File: tb/lpstop_wake_ctrl_tb.sv
`timescale 1ns/1ps
module lpstop_wake_ctrl_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic stop_req = 0, trace_req = 0, keep_int = 0, keep_ext = 0;
  logic ext_clk_mode = 0, ext_src_ok = 1, lock_ok = 0, mod_stop_we = 0;
  logic [2:0] stop_mask = 0, irq_level = 0;
  logic [7:0] relock_len = 0, mod_stop_wd = 0, pad_dir = 0, pad_out_i = 0;
  logic [3:0] bus_strb_i = 0;
  logic [1:0] mode_o;
  logic [2:0] held_mask;
  logic [7:0] mod_stop_q, mod_clk, pad_oe, pad_o;
  logic cpu_clk, int_clk, ext_clk, pll_en;
  logic [3:0] bus_strb_o;

  int n_chk = 0, n_fail = 0;
  logic [1:0] m_mode;
  logic [2:0] m_mask;
  logic [7:0] m_cnt, m_hdir, m_hval, m_bits;

  always #10 clk = ~clk;

  lpstop_wake_ctrl u_dut (
    .clk_ref(clk), .rst_n(rst_n), .stop_req(stop_req), .stop_mask(stop_mask),
    .irq_level(irq_level), .trace_req(trace_req), .keep_int(keep_int),
    .keep_ext(keep_ext), .ext_clk_mode(ext_clk_mode), .ext_src_ok(ext_src_ok),
    .relock_len(relock_len), .lock_ok(lock_ok), .mod_stop_we(mod_stop_we),
    .mod_stop_wd(mod_stop_wd), .pad_dir(pad_dir), .pad_out_i(pad_out_i),
    .bus_strb_i(bus_strb_i), .mode_o(mode_o), .held_mask(held_mask),
    .mod_stop_q(mod_stop_q), .cpu_clk(cpu_clk), .int_clk(int_clk),
    .ext_clk(ext_clk), .mod_clk(mod_clk), .pll_en(pll_en), .pad_oe(pad_oe),
    .pad_o(pad_o), .bus_strb_o(bus_strb_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic bit wakes(input logic [2:0] lvl, input logic [2:0] msk, input logic tr);
    return tr || (lvl > msk) || (lvl == 3'd7);
  endfunction

  task automatic model_step();
    if (mod_stop_we) m_bits = mod_stop_wd;
    case (m_mode)
      2'd0: if (stop_req) begin
        m_mode = 2'd1; m_mask = stop_mask; m_hdir = pad_dir; m_hval = pad_out_i;
      end
      2'd1: if (wakes(irq_level, m_mask, trace_req)) begin
        if (!keep_int && !keep_ext) begin
          m_mode = 2'd2; m_cnt = (relock_len == 0) ? 8'd16 : relock_len;
        end else m_mode = 2'd0;
      end
      default: if (lock_ok || m_cnt == 8'd1) m_mode = 2'd0; else m_cnt = m_cnt - 8'd1;
    endcase
  endtask

  task automatic probe(input logic e_cpu, input logic e_int, input logic e_ext,
                       input logic [7:0] e_mod, input string tag);
    @(posedge clk); #5;
    chk({"R6 cpu_clk ", tag}, cpu_clk, e_cpu);
    chk({"R7 int_clk ", tag}, int_clk, e_int);
    chk({"R8 ext_clk ", tag}, ext_clk, e_ext);
    chk({"R11 mod_clk ", tag}, mod_clk, e_mod);
    @(negedge clk);
  endtask

  task automatic clock_case(input logic ki, input logic ke, input logic xm,
                            input logic xok, input logic [7:0] bits);
    logic down;
    down = !ki && !ke;
    keep_int = ki; keep_ext = ke; ext_clk_mode = xm; ext_src_ok = xok;
    relock_len = 8'd10; mod_stop_we = 1; mod_stop_wd = bits;
    @(negedge clk); mod_stop_we = 0;
    chk("R11 stop bits readback", mod_stop_q, bits);
    probe(1, 1, 1, ~bits, "run");
    stop_mask = 3'd7; irq_level = 0; stop_req = 1;
    @(negedge clk); stop_req = 0;
    chk("R1 enter stop", mode_o, 2'd1);
    chk("R9 pll_en in stop", pll_en, !down);
    probe(0, ki && !(xm && !xok), ke, 8'h00, "stop");
    trace_req = 1;
    @(negedge clk); trace_req = 0;
    chk("R4 trace wake", mode_o, down ? 2'd2 : 2'd0);
    if (down) begin
      probe(0, 0, 0, 8'h00, "relock");
      lock_ok = 1;
      @(negedge clk); lock_ok = 0;
      chk("R10 lock_ok ends relock", mode_o, 2'd0);
    end
  endtask

  task automatic relock_case(input logic [7:0] len, input int exp_n);
    int n;
    keep_int = 0; keep_ext = 0; relock_len = len; stop_mask = 3'd7; irq_level = 0;
    stop_req = 1; @(negedge clk); stop_req = 0;
    irq_level = 3'd7; @(negedge clk); irq_level = 0;
    n = 0;
    while (mode_o == 2'd2 && n < 40) begin n++; @(negedge clk); end
    chk("R9 relock cycles", n, exp_n);
    chk("R9 back to run", mode_o, 2'd0);
  endtask

  task automatic level_case(input logic [2:0] msk, input logic [2:0] lvl, input logic exp_wake);
    keep_int = 1; keep_ext = 1;
    stop_mask = msk; stop_req = 1; @(negedge clk); stop_req = 0;
    irq_level = lvl; @(negedge clk); irq_level = 0;
    chk("R3 level vs mask", mode_o, exp_wake ? 2'd0 : 2'd1);
    if (!exp_wake) begin
      trace_req = 1; @(negedge clk); trace_req = 0;
    end
  endtask

  initial begin
    #(200000 * 20);
    n_fail++;
    $display("FAIL watchdog R1..R12 act=timeout exp=done");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    chk("R5 mode in reset", mode_o, 2'd0);
    chk("R5 mask in reset", held_mask, 3'd0);
    chk("R5 stop bits in reset", mod_stop_q, 8'd0);
    rst_n = 1;
    @(negedge clk);

    level_case(3'd3, 3'd3, 0);
    level_case(3'd3, 3'd4, 1);
    level_case(3'd7, 3'd7, 1);
    level_case(3'd7, 3'd6, 0);
    level_case(3'd0, 3'd0, 0);
    level_case(3'd0, 3'd1, 1);

    keep_int = 1; keep_ext = 1; stop_mask = 3'd2; stop_req = 1;
    @(negedge clk);
    stop_mask = 3'd6;
    @(negedge clk); stop_req = 0;
    chk("R1 repeat stop ignored mode", mode_o, 2'd1);
    chk("R2 repeat stop keeps mask", held_mask, 3'd2);
    irq_level = 3'd3; @(negedge clk); irq_level = 0;
    chk("R2 old mask governs wake", mode_o, 2'd0);

    clock_case(1, 1, 0, 1, 8'h0F);
    clock_case(1, 0, 0, 1, 8'hA5);
    clock_case(0, 1, 0, 1, 8'h00);
    clock_case(0, 0, 0, 1, 8'h81);
    clock_case(1, 1, 1, 0, 8'h3C);
    clock_case(1, 0, 1, 1, 8'hFF);

    relock_case(8'd0, 16);
    relock_case(8'd3, 3);
    relock_case(8'd1, 1);

    m_mode = 0; m_mask = held_mask; m_cnt = 0; m_hdir = 0; m_hval = 0; m_bits = mod_stop_q;
    for (int i = 0; i < 600; i++) begin
      stop_req    = ($urandom % 4) == 0;
      trace_req   = ($urandom % 16) == 0;
      irq_level   = 3'($urandom);
      stop_mask   = 3'($urandom);
      keep_int    = ($urandom % 3) == 0;
      keep_ext    = ($urandom % 3) == 0;
      lock_ok     = ($urandom % 8) == 0;
      relock_len  = 8'($urandom % 6);
      mod_stop_we = ($urandom % 8) == 0;
      mod_stop_wd = 8'($urandom);
      pad_dir     = 8'($urandom);
      pad_out_i   = 8'($urandom);
      bus_strb_i  = 4'($urandom);
      #1;
      chk("R12 pad_oe", pad_oe, (m_mode == 0) ? pad_dir : m_hdir);
      chk("R12 pad_o", pad_o, (m_mode == 0) ? pad_out_i : m_hval);
      chk("R12 strobes", bus_strb_o, (m_mode == 0) ? bus_strb_i : 4'h0);
      chk("R9 pll_en", pll_en, !(m_mode == 1 && !keep_int && !keep_ext));
      model_step();
      @(negedge clk);
      chk("R1 R3 R4 R9 R10 mode", mode_o, m_mode);
      chk("R1 R2 mask", held_mask, m_mask);
      chk("R11 stop bits", mod_stop_q, m_bits);
    end

    stop_req = 0; trace_req = 0; lock_ok = 0; mod_stop_we = 1; mod_stop_wd = 8'hC3;
    @(negedge clk); mod_stop_we = 0;
    #3 rst_n = 0; #2;
    chk("R5 async reset mode", mode_o, 2'd0);
    chk("R5 async reset mask", held_mask, 3'd0);
    chk("R5 async reset bits", mod_stop_q, 8'd0);

    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule